// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

When a load executes, this block looks through the older stores held in a circular store queue. It decides whether the load can take its data straight from a pending store, must be sent to memory, or has to be replayed. The search runs from the store just older than the load's recorded store-queue slot toward older entries, and it ends at the writeback pointer. The youngest store whose bytes overlap the load decides the outcome.

If that store covers every byte the load needs, the load's bytes are cut out of the store's data and returned one cycle later. If the store overlaps only part of the load, the load is rejected for replay. A stall record then keeps the store's sequence number and the index of the oldest load that was rejected this way. If no store overlaps, the load goes to memory. The record clears when its store reports that its memory write has completed.

Top module: `stlf_checker`

## Requirements
- R1: While reset is asserted, `fwd_valid`, `replay`, `mem_req`, `fwd_data` and `stalled` are all zero.
- R2: One clock after a cycle with `ld_valid` high, exactly one of `fwd_valid`, `replay`, `mem_req` is high. One clock after a cycle with `ld_valid` low, all three are low.
- R3: The search covers the slots `ld_sq_idx-1`, `ld_sq_idx-2`, … down to `wb_ptr` inclusive, wrapping modulo the queue depth. When `ld_sq_idx` equals `wb_ptr`, no store is searched.
- R4: A store whose `st_size` is zero, or whose `st_uncache` bit is set, never matches.
- R5: When several stores in the window overlap the load, the one nearest to `ld_sq_idx-1` (the youngest) decides the result.
- R6: A store covers a load fully when ld_addr ≥ st_addr and ld_addr+ld_size ≤ st_addr+st_size. The load is then forwarded. Result byte k (bits 8k+7:8k) equals store data byte (ld_addr AND (st_size−1)) + k for k < ld_size, and every higher byte of `fwd_data` is zero.
- R7: When the deciding store overlaps the load without covering it, `replay` is raised and `fwd_valid` stays low.
- R8: On a replay, the stall record takes the store's `st_seq` and the load's `ld_lq_idx` and sets `stalled`. It does this only if no stall is active, or if the new `ld_seq` is smaller (older) than the recorded load's. Otherwise the record is kept.
- R9: A `done_valid` pulse whose `done_seq` equals `stall_store_seq` clears `stalled` on the next clock. A pulse with any other sequence number leaves it set.
- R10: When no store in the window overlaps the load, `mem_req` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes |
| ld_sq_idx | input | IDX_W | Store-queue slot recorded for the load (one past its youngest older store) |
| ld_lq_idx | input | LQ_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Load sequence number, smaller is older |
| wb_ptr | input | IDX_W | Oldest store not yet written back |
| st_addr | input | SQ_DEPTH×ADDR_W | Store addresses per slot |
| st_size | input | SQ_DEPTH×SIZE_W | Store sizes in bytes per slot |
| st_data | input | SQ_DEPTH×DATA_W | Store data per slot, byte 0 in the low lane |
| st_uncache | input | SQ_DEPTH | Store targets an uncacheable address |
| st_seq | input | SQ_DEPTH×SEQ_W | Store sequence numbers per slot |
| done_valid | input | 1 | A store finished its memory write |
| done_seq | input | SEQ_W | Sequence number of that store |
| fwd_valid | output | 1 | Load forwarded from a store |
| fwd_data | output | DATA_W | Forwarded load data |
| replay | output | 1 | Load hit a partial overlap and must replay |
| mem_req | output | 1 | Load must read memory |
| stalled | output | 1 | A partial-overlap stall is recorded |
| stall_store_seq | output | SEQ_W | Sequence number of the stalling store |
| stall_load_idx | output | LQ_W | Load-queue index of the oldest stalled load |

## Verification
Assertions watch properties that hold on every cycle. At most one result is raised at a time, a result always follows a load and every load gets one. A replay always leaves the stall flag set, a matching completion drops it, and forwarded data is zero above the load's size. Only the bench scenarios can show that the right store is chosen. They exercise window bounds with wraparound, skipped zero-size and uncacheable slots, and youngest-over-older priority. They also check the exact byte offset taken from the store and the rule that keeps the oldest stalled load.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_FULL = 2'd1,
      HIT_PART = 2'd2
   } hit_e;
endpackage

// File: rtl/stlf_range_cmp.sv
module stlf_range_cmp
   import stlf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SIZE_W = 4
) (
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   input  logic              st_uncache,
   output hit_e              cls
);
   logic [ADDR_W:0] l_lo, l_hi, s_lo, s_hi;
   logic            eligible, covers, touches;

   always_comb begin
      l_lo     = {1'b0, ld_addr};
      l_hi     = l_lo + (ADDR_W+1)'(ld_size);
      s_lo     = {1'b0, st_addr};
      s_hi     = s_lo + (ADDR_W+1)'(st_size);
      eligible = (st_size != '0) && !st_uncache;
      covers   = (l_lo >= s_lo) && (l_hi <= s_hi);
      touches  = (l_lo < s_hi) && (l_hi > s_lo);
      if (!eligible)     cls = HIT_NONE;
      else if (covers)   cls = HIT_FULL;
      else if (touches)  cls = HIT_PART;
      else               cls = HIT_NONE;
   end
endmodule

// File: rtl/stlf_scan.sv
module stlf_scan
   import stlf_pkg::*;
#(
   parameter int SQ_DEPTH = 8,
   parameter int ADDR_W   = 16,
   parameter int SIZE_W   = 4,
   localparam int IDX_W   = $clog2(SQ_DEPTH)
) (
   input  logic [ADDR_W-1:0]                ld_addr,
   input  logic [SIZE_W-1:0]                ld_size,
   input  logic [IDX_W-1:0]                 start_idx,
   input  logic [IDX_W-1:0]                 wb_ptr,
   input  logic [SQ_DEPTH-1:0][ADDR_W-1:0]  st_addr,
   input  logic [SQ_DEPTH-1:0][SIZE_W-1:0]  st_size,
   input  logic [SQ_DEPTH-1:0]              st_uncache,
   output hit_e                             sel_cls,
   output logic [IDX_W-1:0]                 sel_idx
);
   hit_e             cls [SQ_DEPTH];
   logic [IDX_W-1:0] span;
   logic [IDX_W-1:0] probe;
   logic             found;

   for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_cmp
      stlf_range_cmp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmp (
         .ld_addr    (ld_addr),
         .ld_size    (ld_size),
         .st_addr    (st_addr[i]),
         .st_size    (st_size[i]),
         .st_uncache (st_uncache[i]),
         .cls        (cls[i])
      );
   end

   // walk from youngest older store toward the writeback pointer
   always_comb begin
      span    = start_idx - wb_ptr;
      found   = 1'b0;
      probe   = '0;
      sel_cls = HIT_NONE;
      sel_idx = '0;
      for (int d = 0; d < SQ_DEPTH; d++) begin
         probe = start_idx - IDX_W'(d + 1);
         if (!found && ((IDX_W+1)'(d) < {1'b0, span}) && (cls[probe] != HIT_NONE)) begin
            found   = 1'b1;
            sel_cls = cls[probe];
            sel_idx = probe;
         end
      end
   end
endmodule

// File: rtl/stlf_extract.sv
module stlf_extract #(
   parameter int DATA_BYTES = 8,
   localparam int SIZE_W    = $clog2(DATA_BYTES) + 1,
   localparam int OFF_W     = $clog2(DATA_BYTES),
   localparam int DATA_W    = DATA_BYTES * 8
) (
   input  logic [DATA_W-1:0] st_data,
   input  logic [SIZE_W-1:0] st_size,
   input  logic [OFF_W-1:0]  addr_low,
   input  logic [SIZE_W-1:0] ld_size,
   output logic [DATA_W-1:0] out_data
);
   logic [OFF_W-1:0]  offset;
   logic [DATA_W-1:0] shifted;

   always_comb begin
      offset  = addr_low & OFF_W'(st_size - SIZE_W'(1));
      shifted = st_data >> {offset, 3'b000};
   end

   for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
      assign out_data[b*8 +: 8] = (SIZE_W'(b) < ld_size) ? shifted[b*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/stlf_stall_track.sv
module stlf_stall_track #(
   parameter int SEQ_W = 16,
   parameter int LQ_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rec_req,
   input  logic [SEQ_W-1:0] rec_store_seq,
   input  logic [SEQ_W-1:0] rec_load_seq,
   input  logic [LQ_W-1:0]  rec_load_idx,
   input  logic             done_valid,
   input  logic [SEQ_W-1:0] done_seq,
   output logic             stalled,
   output logic [SEQ_W-1:0] stall_store_seq,
   output logic [LQ_W-1:0]  stall_load_idx
);
   logic [SEQ_W-1:0] held_load_seq;
   logic             take, release_hit;

   assign take        = rec_req && (!stalled || (rec_load_seq < held_load_seq));
   assign release_hit = done_valid && stalled && (done_seq == stall_store_seq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stalled         <= 1'b0;
         stall_store_seq <= '0;
         stall_load_idx  <= '0;
         held_load_seq   <= '0;
      end else if (take) begin
         stalled         <= 1'b1;
         stall_store_seq <= rec_store_seq;
         stall_load_idx  <= rec_load_idx;
         held_load_seq   <= rec_load_seq;
      end else if (release_hit) begin
         stalled         <= 1'b0;
      end
   end

   a_r8_record_taken: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (stalled && (stall_load_idx == $past(rec_load_idx))))
      else $error("R8 stall record not taken");
   a_r8_younger_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_req && stalled && (rec_load_seq >= held_load_seq)) |=> $stable(stall_load_idx))
      else $error("R8 younger load replaced record");
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && stalled && (done_seq == stall_store_seq) && !rec_req) |=> !stalled)
      else $error("R9 stall not released");
endmodule

// File: rtl/stlf_checker.sv
module stlf_checker
   import stlf_pkg::*;
#(
   parameter int SQ_DEPTH   = 8,
   parameter int LQ_DEPTH   = 16,
   parameter int ADDR_W     = 16,
   parameter int DATA_BYTES = 8,
   parameter int SEQ_W      = 16,
   localparam int IDX_W     = $clog2(SQ_DEPTH),
   localparam int LQ_W      = $clog2(LQ_DEPTH),
   localparam int SIZE_W    = $clog2(DATA_BYTES) + 1,
   localparam int OFF_W     = $clog2(DATA_BYTES),
   localparam int DATA_W    = DATA_BYTES * 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ld_valid,
   input  logic [ADDR_W-1:0]               ld_addr,
   input  logic [SIZE_W-1:0]               ld_size,
   input  logic [IDX_W-1:0]                ld_sq_idx,
   input  logic [LQ_W-1:0]                 ld_lq_idx,
   input  logic [SEQ_W-1:0]                ld_seq,
   input  logic [IDX_W-1:0]                wb_ptr,
   input  logic [SQ_DEPTH-1:0][ADDR_W-1:0] st_addr,
   input  logic [SQ_DEPTH-1:0][SIZE_W-1:0] st_size,
   input  logic [SQ_DEPTH-1:0][DATA_W-1:0] st_data,
   input  logic [SQ_DEPTH-1:0]             st_uncache,
   input  logic [SQ_DEPTH-1:0][SEQ_W-1:0]  st_seq,
   input  logic                            done_valid,
   input  logic [SEQ_W-1:0]                done_seq,
   output logic                            fwd_valid,
   output logic [DATA_W-1:0]               fwd_data,
   output logic                            replay,
   output logic                            mem_req,
   output logic                            stalled,
   output logic [SEQ_W-1:0]                stall_store_seq,
   output logic [LQ_W-1:0]                 stall_load_idx
);
   if ((SQ_DEPTH < 2) || ((SQ_DEPTH & (SQ_DEPTH - 1)) != 0))
      $error("SQ_DEPTH must be a power of two of at least 2");
   if ((DATA_BYTES < 2) || ((DATA_BYTES & (DATA_BYTES - 1)) != 0))
      $error("DATA_BYTES must be a power of two of at least 2");
   if (LQ_DEPTH < 2)
      $error("LQ_DEPTH must be at least 2");
   if (ADDR_W <= OFF_W)
      $error("ADDR_W too narrow");

   hit_e              sel_cls;
   logic [IDX_W-1:0]  sel_idx;
   logic [DATA_W-1:0] cut_data;

   stlf_scan #(.SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_scan (
      .ld_addr    (ld_addr),
      .ld_size    (ld_size),
      .start_idx  (ld_sq_idx),
      .wb_ptr     (wb_ptr),
      .st_addr    (st_addr),
      .st_size    (st_size),
      .st_uncache (st_uncache),
      .sel_cls    (sel_cls),
      .sel_idx    (sel_idx)
   );

   stlf_extract #(.DATA_BYTES(DATA_BYTES)) u_extract (
      .st_data  (st_data[sel_idx]),
      .st_size  (st_size[sel_idx]),
      .addr_low (ld_addr[OFF_W-1:0]),
      .ld_size  (ld_size),
      .out_data (cut_data)
   );

   stlf_stall_track #(.SEQ_W(SEQ_W), .LQ_W(LQ_W)) u_stall (
      .clk             (clk),
      .rst_n           (rst_n),
      .rec_req         (ld_valid && (sel_cls == HIT_PART)),
      .rec_store_seq   (st_seq[sel_idx]),
      .rec_load_seq    (ld_seq),
      .rec_load_idx    (ld_lq_idx),
      .done_valid      (done_valid),
      .done_seq        (done_seq),
      .stalled         (stalled),
      .stall_store_seq (stall_store_seq),
      .stall_load_idx  (stall_load_idx)
   );

   // one-cycle forwarding latency for every outcome
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         replay    <= 1'b0;
         mem_req   <= 1'b0;
         fwd_data  <= '0;
      end else begin
         fwd_valid <= ld_valid && (sel_cls == HIT_FULL);
         replay    <= ld_valid && (sel_cls == HIT_PART);
         mem_req   <= ld_valid && (sel_cls == HIT_NONE);
         fwd_data  <= (ld_valid && (sel_cls == HIT_FULL)) ? cut_data : '0;
      end
   end

   function automatic logic [DATA_W-1:0] keep_mask(input logic [SIZE_W-1:0] n);
      logic [DATA_W-1:0] m;
      for (int b = 0; b < DATA_BYTES; b++)
         m[b*8 +: 8] = (SIZE_W'(b) < n) ? 8'hFF : 8'h00;
      return m;
   endfunction

   a_r2_single_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_valid, replay, mem_req}))
      else $error("R2 more than one result");
   a_r2_load_answered: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> (fwd_valid || replay || mem_req))
      else $error("R2 load without result");
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> !(fwd_valid || replay || mem_req))
      else $error("R2 result without load");
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> ((fwd_data & ~keep_mask($past(ld_size))) == '0))
      else $error("R6 bytes above load size not zero");
   a_r7_replay_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      replay |-> (stalled && !fwd_valid))
      else $error("R7 replay without stall");
endmodule

// File: tb/stlf_checker_bench.sv
module stlf_checker_bench;
   localparam int SQ_DEPTH = 8;
   localparam int DB       = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                   rst_n = 1'b0;
   logic                   ld_valid = 1'b0;
   logic [15:0]            ld_addr = '0;
   logic [3:0]             ld_size = '0;
   logic [2:0]             ld_sq_idx = '0;
   logic [3:0]             ld_lq_idx = '0;
   logic [15:0]            ld_seq = '0;
   logic [2:0]             wb_ptr = '0;
   logic [7:0][15:0]       st_addr;
   logic [7:0][3:0]        st_size;
   logic [7:0][63:0]       st_data;
   logic [7:0]             st_uncache;
   logic [7:0][15:0]       st_seq;
   logic                   done_valid = 1'b0;
   logic [15:0]            done_seq = '0;
   logic                   fwd_valid, replay, mem_req, stalled;
   logic [63:0]            fwd_data;
   logic [15:0]            stall_store_seq;
   logic [3:0]             stall_load_idx;

   stlf_checker u_stlf_checker (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_size(ld_size), .ld_sq_idx(ld_sq_idx), .ld_lq_idx(ld_lq_idx),
      .ld_seq(ld_seq), .wb_ptr(wb_ptr), .st_addr(st_addr), .st_size(st_size),
      .st_data(st_data), .st_uncache(st_uncache), .st_seq(st_seq),
      .done_valid(done_valid), .done_seq(done_seq), .fwd_valid(fwd_valid),
      .fwd_data(fwd_data), .replay(replay), .mem_req(mem_req),
      .stalled(stalled), .stall_store_seq(stall_store_seq),
      .stall_load_idx(stall_load_idx)
   );

   typedef struct {
      logic        f;
      logic        r;
      logic        m;
      logic [63:0] d;
      string       tag;
   } exp_t;

   exp_t expq[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   logic took   = 1'b0;
   bit   ended  = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: present one load, push expected outcome
   task automatic do_load(input logic [15:0] a, input logic [3:0] sz, input logic [2:0] sqi,
                          input logic [3:0] lqi, input logic [15:0] sq,
                          input logic ef, input logic er, input logic em,
                          input logic [63:0] ed, input string tag);
      exp_t e;
      @(negedge clk);
      ld_addr = a; ld_size = sz; ld_sq_idx = sqi; ld_lq_idx = lqi; ld_seq = sq;
      ld_valid = 1'b1;
      e.f = ef; e.r = er; e.m = em; e.d = ed; e.tag = tag;
      expq.push_back(e);
      @(negedge clk);
      ld_valid = 1'b0;
      #2;
   endtask

   // monitor
   always @(posedge clk) took <= ld_valid;
   always @(negedge clk) begin
      #1;
      if (took) begin
         if (expq.size() == 0) begin
            check("R2 unexpected result", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check({e.tag, " result"}, {61'd0, fwd_valid, replay, mem_req}, {61'd0, e.f, e.r, e.m});
            check({e.tag, " data"}, fwd_data, e.d);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < SQ_DEPTH; i++) begin
         st_addr[i] = '0; st_size[i] = '0; st_data[i] = '0; st_seq[i] = 16'(10 + i);
      end
      st_uncache = '0;
      st_addr[0] = 16'h0100; st_size[0] = 4'd8; st_data[0] = 64'h8877665544332211;
      st_addr[1] = 16'h0200; st_size[1] = 4'd4; st_data[1] = 64'h00000000DDCCBBAA;
      st_addr[2] = 16'h0300; st_size[2] = 4'd0; st_data[2] = 64'h0000000012345678;
      st_addr[3] = 16'h0400; st_size[3] = 4'd4; st_data[3] = 64'h0000000099999999;
      st_uncache[3] = 1'b1;
      st_addr[4] = 16'h0104; st_size[4] = 4'd2; st_data[4] = 64'h000000000000EEFF;
      st_addr[7] = 16'h0700; st_size[7] = 4'd8; st_data[7] = 64'h0102030405060708;

      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 reset results", {61'd0, fwd_valid, replay, mem_req}, 64'd0);
      check("R1 reset data", fwd_data, 64'd0);
      check("R1 reset stalled", {63'd0, stalled}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R6 full cover, zero offset
      do_load(16'h0200, 4'd4, 3'd5, 4'd1, 16'd30, 1, 0, 0, 64'h00000000DDCCBBAA, "R6 aligned");
      // R6 offset within store
      do_load(16'h0202, 4'd2, 3'd5, 4'd1, 16'd30, 1, 0, 0, 64'h000000000000DDCC, "R6 offset");
      // R5 youngest store wins over older covering store
      do_load(16'h0104, 4'd2, 3'd5, 4'd1, 16'd30, 1, 0, 0, 64'h000000000000EEFF, "R5 youngest");
      // R3 start one lower excludes slot 4
      do_load(16'h0104, 4'd2, 3'd4, 4'd1, 16'd30, 1, 0, 0, 64'h0000000000006655, "R3 start");
      // R4 zero-size and uncacheable skipped
      do_load(16'h0300, 4'd4, 3'd5, 4'd1, 16'd30, 0, 0, 1, 64'd0, "R4 zero size");
      do_load(16'h0400, 4'd4, 3'd5, 4'd1, 16'd30, 0, 0, 1, 64'd0, "R4 uncacheable");
      // R10 no overlap
      do_load(16'h0500, 4'd4, 3'd5, 4'd1, 16'd30, 0, 0, 1, 64'd0, "R10 memory");

      // R7/R8 partial overlap
      do_load(16'h0103, 4'd4, 3'd5, 4'd3, 16'd50, 0, 1, 0, 64'd0, "R7 partial");
      check("R8 first stall", {47'd0, stalled, stall_store_seq}, {47'd0, 1'b1, 16'd14});
      check("R8 first idx", 64'(stall_load_idx), 64'd3);
      do_load(16'h01FE, 4'd4, 3'd2, 4'd5, 16'd40, 0, 1, 0, 64'd0, "R7 partial older");
      check("R8 older replaces", {47'd0, stalled, stall_store_seq}, {47'd0, 1'b1, 16'd11});
      check("R8 older idx", 64'(stall_load_idx), 64'd5);
      do_load(16'h0103, 4'd4, 3'd5, 4'd6, 16'd60, 0, 1, 0, 64'd0, "R7 partial younger");
      check("R8 younger kept", {47'd0, stalled, stall_store_seq}, {47'd0, 1'b1, 16'd11});
      check("R8 younger idx", 64'(stall_load_idx), 64'd5);

      // R9 completion of another store does not clear
      @(negedge clk);
      done_valid = 1'b1; done_seq = 16'd14;
      @(negedge clk);
      done_valid = 1'b0;
      #1;
      check("R9 other store", 64'(stalled), 64'd1);
      done_valid = 1'b1; done_seq = 16'd11;
      @(negedge clk);
      done_valid = 1'b0;
      #1;
      check("R9 matching store", 64'(stalled), 64'd0);

      // R3 empty window and window bounded by writeback pointer
      wb_ptr = 3'd1;
      do_load(16'h0200, 4'd4, 3'd1, 4'd2, 16'd70, 0, 0, 1, 64'd0, "R3 empty window");
      do_load(16'h0104, 4'd2, 3'd2, 4'd2, 16'd70, 0, 0, 1, 64'd0, "R3 wb bound");
      // R3 wraparound window 0,7,6
      wb_ptr = 3'd6;
      do_load(16'h0706, 4'd2, 3'd1, 4'd2, 16'd70, 1, 0, 0, 64'h0000000000000102, "R3 wrap");

      // R2 idle cycle gives no result
      @(negedge clk);
      #1;
      check("R2 idle", {61'd0, fwd_valid, replay, mem_req}, 64'd0);
      check("R2 queue drained", 64'(expq.size()), 64'd0);

      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule